// File: doc/BRIEF.md
# Bunch-Crossing Capture Sequencer

This block runs the per-crossing readout cycle of one calorimeter channel. It runs on a 50 ns master clock. A one-cycle crossing strobe starts a fixed seven-cycle sequence. On the fourth edge after the strobe is taken, the sequence latches the trigger comparator. On the fifth edge it latches the gain comparator. During the sixth cycle it issues exactly one of two pulses: memorize, which keeps the active analog cell, or integrator reset, which discards it.

A write pointer walks across a sixteen-cell analog memory. It moves only when a cell is kept, so a discarded crossing reuses the same cell. For every kept cell, the gain decision is stored as a one-bit range tag that a read port can fetch later, when the converter chooses the high- or low-gain path. Once all sixteen cells are in use, the full flag rises and further crossings are refused. A synchronous clear opens each new acquisition window.

Top module: `crossingCaptureSeq`

## Requirements
- R1: After asynchronous reset (rstN low) or a clear, memorize and integReset are low, cellIdx is 0, full is 0 and every gain tag reads 0.
- R2: A strobe is accepted on the edge where bxStrobe is high while the sequencer is ready and not full. trigIn is sampled only on the 4th rising edge after that accept edge.
- R3: gainIn is sampled only on the 5th rising edge after the accept edge.
- R4: Exactly one decision pulse, one cycle wide, is driven during the cycle that ends at the 6th edge. memorize is high if the sampled trigger was 1, and integReset is high if it was 0.
- R5: During a decision pulse, cellIdx is the active cell. The pointer advances by one after memorize and stays unchanged after integReset.
- R6: rdGain (combinational from rdIdx) returns the gain sampled for that stored cell. A value of 1 means the high-gain path is to be converted.
- R7: A strobe seen during cycles 1 to 6 of a sequence is ignored. A strobe in cycle 7 is accepted, so crossings may follow each other seven cycles apart.
- R8: full is high exactly when 16 cells are stored. While full, a strobe produces no decision pulse and changes no state.
- R9: clearAcq, sampled on a rising edge, zeroes the pointer, the tags and full, and aborts any running sequence. It overrides an accept in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearAcq | input | 1 | Synchronous clear at the start of an acquisition window |
| bxStrobe | input | 1 | Crossing strobe, one cycle |
| trigIn | input | 1 | Trigger comparator output |
| gainIn | input | 1 | Gain comparator output (1 = high gain) |
| rdIdx | input | 4 | Cell index for tag readout |
| integReset | output | 1 | Discard pulse that resets the active cell |
| memorize | output | 1 | Keep pulse that stores the active cell |
| cellIdx | output | 4 | Active write cell |
| full | output | 1 | All 16 cells occupied |
| rdGain | output | 1 | Gain tag of cell rdIdx |

## Verification
On every cycle, the assertions check the following: each decision pulse is a single cycle wide; the pointer moves by one on memorize and holds on a discard; nothing is stored while full; a clear empties the memory; and the phase counter runs on undisturbed through strobes that arrive mid-sequence. Other properties depend on input values placed in one exact cycle, so only the bench scenarios show them. These are the exact trigger and gain sampling offsets, the tag contents read back per cell, acceptance of a strobe in the seventh cycle, and the silence of a crossing refused while full. The bench drives the opposite comparator level in the neighbouring cycles, so sampling one cycle off changes the decision.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef struct packed {
    logic gainSample;
    logic store;
    logic discard;
    logic clear;
  } seqStb_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int TRIG_AT  = 4,
  parameter int GAIN_AT  = 5,
  parameter int END_AT   = 6,
  parameter int READY_AT = 7
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    clearAcq,
  input  logic    bxStrobe,
  input  logic    trigIn,
  input  logic    full,
  output seqStb_t stb
);
  localparam int CNT_W = $clog2(READY_AT + 1);

  logic [CNT_W-1:0] phase;
  logic trigLat;
  logic ready;
  logic accept;

  assign ready  = (phase == '0) || (phase == CNT_W'(READY_AT));
  assign accept = ready && bxStrobe && !full && !clearAcq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      trigLat <= 1'b0;
    end else if (clearAcq) begin
      phase   <= '0;
      trigLat <= 1'b0;
    end else begin
      if (accept)                           phase <= CNT_W'(1);
      else if (phase == CNT_W'(READY_AT))   phase <= '0;
      else if (phase != '0)                 phase <= phase + CNT_W'(1);
      if (phase == CNT_W'(TRIG_AT)) trigLat <= trigIn;
    end
  end

  always_comb begin
    stb.gainSample = (phase == CNT_W'(GAIN_AT));
    stb.store      = (phase == CNT_W'(END_AT)) && trigLat;
    stb.discard    = (phase == CNT_W'(END_AT)) && !trigLat;
    stb.clear      = clearAcq;
  end

  // R7: mid-sequence strobes never disturb the phase count
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !clearAcq) |=> (phase == $past(phase) + CNT_W'(1)));

  // R4: decision pulse lasts exactly one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (stb.store || stb.discard) |=> !(stb.store || stb.discard));
endmodule

// File: rtl/seqData.sv
module seqData
  import seqPkg::*;
#(
  parameter int CELLS = 16,
  localparam int PTR_W = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStb_t          stb,
  input  logic             gainIn,
  input  logic [PTR_W-1:0] rdIdx,
  output logic [PTR_W-1:0] cellIdx,
  output logic             full,
  output logic             rdGain
);
  logic [PTR_W:0]   usedCnt;
  logic             gainLat;
  logic [CELLS-1:0] tags;

  assign full    = (usedCnt == (PTR_W+1)'(CELLS));
  assign cellIdx = usedCnt[PTR_W-1:0];
  assign rdGain  = tags[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedCnt <= '0;
      gainLat <= 1'b0;
      tags    <= '0;
    end else if (stb.clear) begin
      usedCnt <= '0;
      gainLat <= 1'b0;
      tags    <= '0;
    end else begin
      if (stb.gainSample) gainLat <= gainIn;
      if (stb.store) begin
        tags[cellIdx] <= gainLat;
        usedCnt       <= usedCnt + (PTR_W+1)'(1);
      end
    end
  end

  // R5: pointer advances on store, holds on discard
  a_r5_advance: assert property (@(posedge clk) disable iff (!rstN)
    (stb.store && !stb.clear) |=> (usedCnt == $past(usedCnt) + (PTR_W+1)'(1)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stb.discard && !stb.clear) |=> $stable(usedCnt));
  // R8: control never stores into a full memory
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !stb.store);
  // R9: clear empties the memory
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (usedCnt == '0 && tags == '0));
endmodule

// File: rtl/crossingCaptureSeq.sv
module crossingCaptureSeq
  import seqPkg::*;
#(
  parameter int CELLS    = 16,
  parameter int TRIG_AT  = 4,
  parameter int GAIN_AT  = 5,
  parameter int END_AT   = 6,
  parameter int READY_AT = 7,
  localparam int PTR_W   = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clearAcq,
  input  logic             bxStrobe,
  input  logic             trigIn,
  input  logic             gainIn,
  input  logic [PTR_W-1:0] rdIdx,
  output logic             integReset,
  output logic             memorize,
  output logic [PTR_W-1:0] cellIdx,
  output logic             full,
  output logic             rdGain
);
  seqStb_t stb;

  seqCtrl #(.TRIG_AT(TRIG_AT), .GAIN_AT(GAIN_AT), .END_AT(END_AT), .READY_AT(READY_AT)) u_ctrl (
    .clk(clk), .rstN(rstN), .clearAcq(clearAcq), .bxStrobe(bxStrobe),
    .trigIn(trigIn), .full(full), .stb(stb)
  );

  seqData #(.CELLS(CELLS)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .gainIn(gainIn), .rdIdx(rdIdx),
    .cellIdx(cellIdx), .full(full), .rdGain(rdGain)
  );

  assign memorize   = stb.store;
  assign integReset = stb.discard;
endmodule

// File: tb/crossingCaptureSeq_tb.sv
module crossingCaptureSeq_tb;
  logic clk = 0, rstN = 0, clearAcq = 0, bxStrobe = 0, trigIn = 0, gainIn = 0;
  logic [3:0] rdIdx = 0;
  logic integReset, memorize, full, rdGain;
  logic [3:0] cellIdx;
  int tests = 0, fails = 0;
  int modelPtr = 0;
  logic [4:0] expQ[$];

  always #2.5 clk = ~clk;

  crossingCaptureSeq u_dut (
    .clk(clk), .rstN(rstN), .clearAcq(clearAcq), .bxStrobe(bxStrobe),
    .trigIn(trigIn), .gainIn(gainIn), .rdIdx(rdIdx), .integReset(integReset),
    .memorize(memorize), .cellIdx(cellIdx), .full(full), .rdGain(rdGain)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop expected decisions (R2 R3 R4 R5)
  always @(negedge clk) begin
    if (rstN && (memorize || integReset)) begin
      if (expQ.size() == 0) begin
        check(0, "R7/R8 unexpected pulse", {memorize, cellIdx}, -1);
      end else begin
        logic [4:0] e;
        e = expQ.pop_front();
        check(!(memorize && integReset), "R4 both pulses", 3, 1);
        check({memorize, cellIdx} == e, "R4/R5 decision", {memorize, cellIdx}, e);
      end
    end
  end

  // driver: one crossing; trigger/gain valid only in their own cycle (R2 R3)
  task automatic runEvent(input bit t, input bit g, input bit extra);
    @(negedge clk); bxStrobe = 1;
    if (modelPtr < 16) begin
      expQ.push_back({t, 4'(modelPtr)});
      if (t) modelPtr++;
    end
    @(negedge clk); bxStrobe = 0;
    @(negedge clk);
    @(negedge clk); if (extra) bxStrobe = 1;
    @(negedge clk); bxStrobe = 0; trigIn = t;
    @(negedge clk); trigIn = ~t; gainIn = g;
    @(negedge clk); trigIn = 0; gainIn = ~g;
  endtask

  task automatic mainSeq;
    repeat (3) @(negedge clk);
    check(!memorize && !integReset, "R1 reset pulses", memorize, 0);
    check(cellIdx == 0, "R1 reset cellIdx", cellIdx, 0);
    check(full == 0, "R1 reset full", full, 0);
    check(rdGain == 0, "R1 reset tag", rdGain, 0);
    rstN = 1;
    runEvent(1, 1, 0);          // R2 store cell 0 high gain
    runEvent(0, 1, 0);          // R4 discard reuses cell 1
    runEvent(1, 0, 1);          // R7 extra strobe ignored
    runEvent(1, 1, 0);          // R7 back-to-back accept
    @(negedge clk); gainIn = 0;
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R7 all decisions seen", expQ.size(), 0);
    check(cellIdx == 3, "R5 pointer", cellIdx, 3);
    rdIdx = 0; #1 check(rdGain == 1, "R6 tag0", rdGain, 1);
    rdIdx = 1; #1 check(rdGain == 0, "R6 tag1", rdGain, 0);
    rdIdx = 2; #1 check(rdGain == 1, "R3 R6 tag2", rdGain, 1);
    for (int i = 3; i < 16; i++) runEvent(1, i[0], 0);
    repeat (3) @(negedge clk);
    check(full == 1, "R8 full", full, 1);
    rdIdx = 7; #1 check(rdGain == 1, "R6 tag7", rdGain, 1);
    rdIdx = 8; #1 check(rdGain == 0, "R6 tag8", rdGain, 0);
    runEvent(1, 1, 0);          // refused while full
    repeat (8) @(negedge clk);
    check(expQ.size() == 0 && full, "R8 strobe ignored when full", expQ.size(), 0);
    rdIdx = 0; #1 check(rdGain == 1, "R8 tags unchanged", rdGain, 1);
    @(negedge clk); clearAcq = 1;
    @(negedge clk); clearAcq = 0;
    check(full == 0 && cellIdx == 0, "R9 clear state", {full, cellIdx}, 0);
    #1 check(rdGain == 0, "R9 tags cleared", rdGain, 0);
    modelPtr = 0;
    // abort: strobe then clear mid-sequence, no pulse expected
    @(negedge clk); bxStrobe = 1;
    @(negedge clk); bxStrobe = 0;
    @(negedge clk); clearAcq = 1; trigIn = 1;
    @(negedge clk); clearAcq = 0;
    repeat (8) @(negedge clk); trigIn = 0;
    check(cellIdx == 0, "R9 abort no store", cellIdx, 0);
    runEvent(1, 0, 0);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0 && cellIdx == 1, "R9 resumes after clear", cellIdx, 1);
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule